// File: doc/BRIEF.md
# SPI Burst Master

This block is a single-device SPI master that runs fixed-length byte bursts from a register bus. Software fills a transmit FIFO with the bytes to send, for example a command byte and an address. It writes the total burst length and the number of bytes taken from the transmit FIFO, then sets a start bit. The controller lowers chip select and shifts the whole burst in SPI mode 0, MSB first. Once the transmit bytes run out, it pads the burst with 0x00 bytes.

Every byte clocked in on MISO is stored in a receive FIFO, including the bytes received while the header goes out. Software waits until the receive count reaches the burst length. It then discards the header bytes and reads the payload. The start bit clears itself when the burst ends, so it also serves as a busy flag.

The serial clock comes from the system clock. An even-divider mode divides by 2×(N+1). Outside that mode the clock is fixed at divide-by-2.

Top module: `spi_burst_master`

## Requirements
- R1: After reset, cs_n_o is 1, sck_o is 0, and the control, start, status and clock-divider registers read 0.
- R2: Control register (offset 0x00) bit 0 is enable and bit 1 is master mode, both read back as written. Writing 1 to bit 31 requests a soft reset. Bit 31 reads 1 in the cycle after the write and 0 from the cycle after that. The soft reset empties both FIFOs, ends any burst and releases chip select.
- R3: A write to the TX data register (offset 0x20) pushes bits 7:0 into a 64-entry FIFO. A push into a full FIFO is dropped, and the TX level (status bits 22:16) stays at 64.
- R4: A read of the RX data register (offset 0x30) pops one byte into bits 7:0. A read while the RX FIFO is empty returns 0.
- R5: During a burst, bytes are shifted MSB first in SPI mode 0. MOSI changes only while SCK is low, and MISO is sampled on the rising edge of SCK. The transmit-count bytes come from the TX FIFO in push order, and all later bytes are 0x00.
- R6: The number of bytes taken from the TX FIFO is the smaller of the transmit count (offset 0x0C) and the burst-control count (offset 0x10).
- R7: Every byte of a burst, header included, is pushed into the RX FIFO. Status bits 6:0 give the RX FIFO level.
- R8: Writing 1 to bit 31 of the start register (offset 0x04) starts a burst of exactly the burst count (offset 0x08) bytes. Bit 31 reads 1 until the burst ends, then clears itself. Chip select stays low for the whole burst without a break.
- R9: Clock-divider register (offset 0x14): when bit 12 is 1, the SCK period is 2×(N+1) system clocks, where N is bits 3:0. When bit 12 is 0, the period is 2 clocks. SCK idles low.
- R10: A start request has no effect when enable or master mode is clear, or when the burst count is 0.
- R11: Bytes received while the RX FIFO is full are dropped, and the level stays at 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops RX data) |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from address |
| sck_o | output | 1 | Serial clock |
| cs_n_o | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
Read data is combinational from the address, so the bench samples it 1 ns after driving a read in the low phase of the clock. Register writes take effect at the next rising edge. The soft-reset bit is due to read 1 in the cycle right after its write and 0 in the cycle after that, and the bench reads it in exactly those two cycles. The end of a burst depends on the divider, so the bench polls the start bit rather than counting to a fixed cycle. It then compares the bytes seen by its SPI slave model and the RX FIFO contents with values it computes itself. The SCK period is measured between successive rising edges and compared with 2×(N+1) clocks.

// File: rtl/spi_burst_pkg.sv
`timescale 1ns/1ps
package spi_burst_pkg;
  localparam int unsigned REG_AW = 8;

  localparam logic [REG_AW-1:0] A_CTRL   = 8'h00;
  localparam logic [REG_AW-1:0] A_XFER   = 8'h04;
  localparam logic [REG_AW-1:0] A_BURST  = 8'h08;
  localparam logic [REG_AW-1:0] A_TXCNT  = 8'h0C;
  localparam logic [REG_AW-1:0] A_STXCNT = 8'h10;
  localparam logic [REG_AW-1:0] A_CLKDIV = 8'h14;
  localparam logic [REG_AW-1:0] A_STAT   = 8'h18;
  localparam logic [REG_AW-1:0] A_TXD    = 8'h20;
  localparam logic [REG_AW-1:0] A_RXD    = 8'h30;

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SHIFT, ST_TRAIL} eng_state_e;
endpackage

// File: rtl/spi_byte_fifo.sv
`timescale 1ns/1ps
module spi_byte_fifo #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] dout_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic do_push, do_pop;

  assign do_push = push_i && (cnt_q != CW'(DEPTH));
  assign do_pop  = pop_i && (cnt_q != '0);
  assign dout_o  = mem_q[rd_q];
  assign count_o = cnt_q;
  assign empty_o = (cnt_q == '0);

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/spi_sck_timer.sv
`timescale 1ns/1ps
module spi_sck_timer #(
  parameter int unsigned HW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [HW-1:0] half_i,
  output logic          tick_o
);
  logic [HW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == half_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_shift_engine.sv
`timescale 1ns/1ps
module spi_shift_engine
  import spi_burst_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             abort_i,
  input  logic             go_i,
  input  logic [CNT_W-1:0] burst_i,
  input  logic [CNT_W-1:0] take_i,
  input  logic             tick_i,
  input  logic [7:0]       tx_data_i,
  input  logic             tx_empty_i,
  output logic             tx_pop_o,
  output logic             rx_push_o,
  output logic [7:0]       rx_data_o,
  input  logic             miso_i,
  output logic             sck_o,
  output logic             mosi_o,
  output logic             cs_n_o,
  output logic             run_o,
  output logic             done_o
);
  eng_state_e       state_q;
  logic [CNT_W-1:0] left_q, txleft_q, cur_txl;
  logic [7:0]       tsh_q, rsh_q, nbyte;
  logic [2:0]       bit_q;
  logic             sck_q, cs_n_q, has_tx, fifo_ok;

  // next outgoing byte: from FIFO while transmit count remains, else filler
  assign cur_txl = (state_q == ST_IDLE) ? take_i : txleft_q;
  assign has_tx  = (cur_txl != '0);
  assign fifo_ok = has_tx && !tx_empty_i;
  assign nbyte   = fifo_ok ? tx_data_i : 8'h00;

  assign sck_o  = sck_q;
  assign cs_n_o = cs_n_q;
  assign mosi_o = tsh_q[7];
  assign run_o  = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      left_q    <= '0;
      txleft_q  <= '0;
      tsh_q     <= '0;
      rsh_q     <= '0;
      bit_q     <= '0;
      sck_q     <= 1'b0;
      cs_n_q    <= 1'b1;
      tx_pop_o  <= 1'b0;
      rx_push_o <= 1'b0;
      rx_data_o <= '0;
      done_o    <= 1'b0;
    end else begin
      tx_pop_o  <= 1'b0;
      rx_push_o <= 1'b0;
      done_o    <= 1'b0;
      if (abort_i) begin
        state_q <= ST_IDLE;
        sck_q   <= 1'b0;
        cs_n_q  <= 1'b1;
        tsh_q   <= '0;
      end else begin
        case (state_q)
          ST_IDLE: if (go_i) begin
            cs_n_q   <= 1'b0;
            left_q   <= burst_i;
            tsh_q    <= nbyte;
            tx_pop_o <= fifo_ok;
            txleft_q <= has_tx ? cur_txl - 1'b1 : cur_txl;
            bit_q    <= '0;
            state_q  <= ST_LEAD;
          end
          ST_LEAD: if (tick_i) begin
            sck_q   <= 1'b1;
            rsh_q   <= {rsh_q[6:0], miso_i};
            state_q <= ST_SHIFT;
          end
          ST_SHIFT: if (tick_i) begin
            if (sck_q) begin
              sck_q <= 1'b0;
              if (bit_q == 3'd7) begin
                rx_push_o <= 1'b1;
                rx_data_o <= rsh_q;
                left_q    <= left_q - 1'b1;
                bit_q     <= '0;
                if (left_q == CNT_W'(1)) begin
                  state_q <= ST_TRAIL;
                end else begin
                  tsh_q    <= nbyte;
                  tx_pop_o <= fifo_ok;
                  txleft_q <= has_tx ? cur_txl - 1'b1 : cur_txl;
                end
              end else begin
                tsh_q <= {tsh_q[6:0], 1'b0};
                bit_q <= bit_q + 1'b1;
              end
            end else begin
              sck_q <= 1'b1;
              rsh_q <= {rsh_q[6:0], miso_i};
            end
          end
          ST_TRAIL: if (tick_i) begin
            cs_n_q  <= 1'b1;
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_burst_master.sv
`timescale 1ns/1ps
module spi_burst_master
  import spi_burst_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 64,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned DIV_W      = 4,
  localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH) + 1,
  localparam int unsigned HALF_W    = DIV_W + 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic        reg_re_i,
  input  logic [7:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        sck_o,
  output logic        cs_n_o,
  output logic        mosi_o,
  input  logic        miso_i
);
  logic             en_q, master_q, srst_q, xch_q, div_mode_q;
  logic [DIV_W-1:0] div_n_q;
  logic [CNT_W-1:0] burst_q, txcnt_q, stx_q, take;
  logic [HALF_W-1:0] half;
  logic             go, tick, run, done;
  logic             tx_pop, tx_empty, rx_push, rx_pop, rx_empty;
  logic [7:0]       tx_head, rx_byte, rx_head;
  logic [LVL_W-1:0] tx_lvl, rx_lvl;
  logic             wr_ctrl, wr_xfer, wr_txd;

  assign wr_ctrl = reg_we_i && (reg_addr_i == A_CTRL);
  assign wr_xfer = reg_we_i && (reg_addr_i == A_XFER);
  assign wr_txd  = reg_we_i && (reg_addr_i == A_TXD);
  assign rx_pop  = reg_re_i && (reg_addr_i == A_RXD);

  assign go   = wr_xfer && reg_wdata_i[31] && en_q && master_q && !xch_q &&
                !srst_q && (burst_q != '0);
  assign take = (txcnt_q < stx_q) ? txcnt_q : stx_q;
  assign half = div_mode_q ? HALF_W'(div_n_q) + 1'b1 : HALF_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      master_q   <= 1'b0;
      srst_q     <= 1'b0;
      xch_q      <= 1'b0;
      div_mode_q <= 1'b0;
      div_n_q    <= '0;
      burst_q    <= '0;
      txcnt_q    <= '0;
      stx_q      <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q     <= reg_wdata_i[0];
        master_q <= reg_wdata_i[1];
      end
      srst_q <= wr_ctrl && reg_wdata_i[31] && !srst_q;
      if (srst_q)    xch_q <= 1'b0;
      else if (go)   xch_q <= 1'b1;
      else if (done) xch_q <= 1'b0;
      if (reg_we_i) begin
        case (reg_addr_i)
          A_BURST:  burst_q <= reg_wdata_i[CNT_W-1:0];
          A_TXCNT:  txcnt_q <= reg_wdata_i[CNT_W-1:0];
          A_STXCNT: stx_q   <= reg_wdata_i[CNT_W-1:0];
          A_CLKDIV: begin
            div_mode_q <= reg_wdata_i[12];
            div_n_q    <= reg_wdata_i[DIV_W-1:0];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL:   reg_rdata_o = {srst_q, 29'd0, master_q, en_q};
      A_XFER:   reg_rdata_o = {xch_q, 31'd0};
      A_BURST:  reg_rdata_o[CNT_W-1:0] = burst_q;
      A_TXCNT:  reg_rdata_o[CNT_W-1:0] = txcnt_q;
      A_STXCNT: reg_rdata_o[CNT_W-1:0] = stx_q;
      A_CLKDIV: begin
        reg_rdata_o[12]        = div_mode_q;
        reg_rdata_o[DIV_W-1:0] = div_n_q;
      end
      A_STAT: begin
        reg_rdata_o[LVL_W-1:0]     = rx_lvl;
        reg_rdata_o[16+:LVL_W]     = tx_lvl;
      end
      A_RXD:    reg_rdata_o[7:0] = rx_empty ? 8'h00 : rx_head;
      default:  reg_rdata_o = '0;
    endcase
  end

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_tx_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(srst_q),
    .push_i(wr_txd), .din_i(reg_wdata_i[7:0]),
    .pop_i(tx_pop), .dout_o(tx_head), .count_o(tx_lvl), .empty_o(tx_empty)
  );

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_rx_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(srst_q),
    .push_i(rx_push), .din_i(rx_byte),
    .pop_i(rx_pop), .dout_o(rx_head), .count_o(rx_lvl), .empty_o(rx_empty)
  );

  spi_sck_timer #(.HW(HALF_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .half_i(half), .tick_o(tick)
  );

  spi_shift_engine #(.CNT_W(CNT_W)) u_engine (
    .clk_i(clk_i), .rst_ni(rst_ni), .abort_i(srst_q), .go_i(go),
    .burst_i(burst_q), .take_i(take), .tick_i(tick),
    .tx_data_i(tx_head), .tx_empty_i(tx_empty), .tx_pop_o(tx_pop),
    .rx_push_o(rx_push), .rx_data_o(rx_byte), .miso_i(miso_i),
    .sck_o(sck_o), .mosi_o(mosi_o), .cs_n_o(cs_n_o),
    .run_o(run), .done_o(done)
  );
endmodule

// File: rtl/spi_burst_checks.sv
`timescale 1ns/1ps
module spi_burst_checks #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned LW    = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_n_i,
  input logic          sck_i,
  input logic          xch_i,
  input logic          srst_i,
  input logic [LW-1:0] tx_lvl_i,
  input logic [LW-1:0] rx_lvl_i
);
  assert_cs_in_burst_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n_i |-> xch_i);
  assert_sck_idle_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |-> !sck_i);
  assert_srst_selfclear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> !srst_i);
  assert_srst_flush_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (tx_lvl_i == '0 && rx_lvl_i == '0 && cs_n_i));
  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_lvl_i <= LW'(DEPTH));
  assert_rx_bound_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_lvl_i <= LW'(DEPTH));
endmodule

bind spi_burst_master spi_burst_checks #(.DEPTH(FIFO_DEPTH), .LW(LVL_W)) u_checks (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_n_i(cs_n_o), .sck_i(sck_o),
  .xch_i(xch_q), .srst_i(srst_q), .tx_lvl_i(tx_lvl), .rx_lvl_i(rx_lvl)
);

// File: tb/spi_burst_master_tb.sv
`timescale 1ns/1ps
module spi_burst_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        sck, cs_n, mosi, miso = 1'b0;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int cs_falls = 0;
  int slv_cnt = 0;
  logic [7:0] slv_log [128];
  logic [7:0] slv_seed = 8'h00;
  logic [7:0] txbuf [64];
  longint last_rise = 0, sck_period = 0;

  always #2 clk = ~clk;

  spi_burst_master dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .sck_o(sck), .cs_n_o(cs_n), .mosi_o(mosi), .miso_i(miso)
  );

  function automatic logic [7:0] slv_byte(input int k, input logic [7:0] s);
    return (8'h5A ^ s) + 8'(k * 37);
  endfunction

  // SPI slave model, mode 0
  initial begin
    forever begin
      @(negedge cs_n);
      cs_falls++;
      slv_cnt = 0;
      begin
        logic [7:0] sh;
        int bc;
        bc = 0;
        sh = '0;
        miso = slv_byte(0, slv_seed)[7];
        forever begin
          @(posedge sck or posedge cs_n);
          if (cs_n) break;
          sh = {sh[6:0], mosi};
          bc++;
          if (bc == 8) begin
            if (slv_cnt < 128) slv_log[slv_cnt] = sh;
            slv_cnt++;
            bc = 0;
          end
          @(negedge sck or posedge cs_n);
          if (cs_n) break;
          miso = slv_byte(slv_cnt, slv_seed)[7 - bc];
        end
      end
    end
  end

  always @(posedge sck) begin
    sck_period = $time - last_rise;
    last_rise  = $time;
  end

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    re = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(8'h04, v);
      if (!v[31]) return;
    end
  endtask

  task automatic soft_reset();
    logic [31:0] v;
    rd(8'h00, v);
    wr(8'h00, {1'b1, 29'd0, v[1:0]});
    @(negedge clk);
  endtask

  // run one burst and check MOSI, RX FIFO and start bit
  task automatic burst(input int blen, input int tcnt, input int scnt, input int npush,
                       input logic [7:0] seed);
    logic [31:0] v;
    int take, nrx;
    soft_reset();
    for (int i = 0; i < npush; i++) begin
      txbuf[i] = 8'($urandom);
      wr(8'h20, {24'd0, txbuf[i]});
    end
    wr(8'h08, blen);
    wr(8'h0C, tcnt);
    wr(8'h10, scnt);
    slv_seed = seed;
    wr(8'h04, 32'h8000_0000);
    rd(8'h04, v);
    chk(v[31] == 1'b1, "R8 start bit set during burst", v[31], 1);
    chk(cs_n == 1'b0, "R8 cs low during burst", cs_n, 0);
    wait_idle();
    rd(8'h04, v);
    chk(v[31] == 1'b0, "R8 start bit self-clears", v[31], 0);
    chk(slv_cnt == blen, "R8 burst length on wire", slv_cnt, blen);
    take = (tcnt < scnt) ? tcnt : scnt;
    for (int k = 0; k < blen && k < 128; k++) begin
      logic [7:0] e;
      e = (k < take && k < npush) ? txbuf[k] : 8'h00;
      chk(slv_log[k] == e, "R5 R6 MOSI byte", slv_log[k], e);
    end
    nrx = (blen > 64) ? 64 : blen;
    rd(8'h18, v);
    chk(v[6:0] == 7'(nrx), "R7 R11 RX level", v[6:0], nrx);
    for (int k = 0; k < nrx; k++) begin
      rd(8'h30, v);
      chk(v[7:0] == slv_byte(k, seed), "R7 RX byte", v[7:0], slv_byte(k, seed));
    end
  endtask

  initial begin
    logic [31:0] v;
    int f0;
    void'($urandom(32'h1F2E3D4C));
    #11 rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(cs_n == 1'b1, "R1 cs_n after reset", cs_n, 1);
    chk(sck == 1'b0, "R1 sck after reset", sck, 0);
    rd(8'h00, v); chk(v == 0, "R1 ctrl reset", v, 0);
    rd(8'h04, v); chk(v == 0, "R1 start reset", v, 0);
    rd(8'h18, v); chk(v == 0, "R1 status reset", v, 0);
    rd(8'h14, v); chk(v == 0, "R1 clkdiv reset", v, 0);

    // R4 empty RX read
    rd(8'h30, v); chk(v == 0, "R4 empty RX read", v, 0);

    // R10 start ignored while disabled
    wr(8'h08, 4);
    f0 = cs_falls;
    wr(8'h04, 32'h8000_0000);
    rd(8'h04, v); chk(v[31] == 1'b0, "R10 start ignored when disabled", v[31], 0);
    repeat (20) @(negedge clk);
    chk(cs_falls == f0, "R10 no chip select when disabled", cs_falls, f0);

    // R2 control bits
    wr(8'h00, 32'h1);
    wr(8'h04, 32'h8000_0000);
    rd(8'h04, v); chk(v[31] == 1'b0, "R10 start ignored without master", v[31], 0);
    wr(8'h00, 32'h3);
    rd(8'h00, v); chk(v == 32'h3, "R2 ctrl readback", v, 3);

    // R10 zero burst
    wr(8'h08, 0);
    wr(8'h04, 32'h8000_0000);
    rd(8'h04, v); chk(v[31] == 1'b0, "R10 zero burst ignored", v[31], 0);
    repeat (10) @(negedge clk);
    chk(cs_falls == f0, "R10 no chip select on zero burst", cs_falls, f0);

    // R3 full TX FIFO
    for (int i = 0; i < 66; i++) wr(8'h20, i);
    rd(8'h18, v); chk(v[22:16] == 7'd64, "R3 TX level saturates", v[22:16], 64);

    // R2 soft reset timing and flush
    wr(8'h00, 32'h8000_0003);
    rd(8'h00, v); chk(v[31] == 1'b1, "R2 soft reset bit visible", v[31], 1);
    rd(8'h00, v); chk(v == 32'h3, "R2 soft reset self-clears", v, 3);
    rd(8'h18, v); chk(v == 0, "R2 soft reset flushes FIFOs", v, 0);

    // R5 R7 read-command style header with payload
    burst(12, 4, 4, 4, 8'h11);
    // R6 burst-control count smaller than transmit count
    burst(8, 6, 3, 6, 8'h22);
    // R9 divider settings
    wr(8'h14, 32'h1000);
    rd(8'h14, v); chk(v == 32'h1000, "R9 clkdiv readback", v, 32'h1000);
    burst(2, 1, 1, 1, 8'h33);
    chk(sck_period == 8, "R9 divide by 2 period ns", sck_period, 8);
    wr(8'h14, 32'h1001);
    burst(2, 1, 1, 1, 8'h44);
    chk(sck_period == 16, "R9 divide by 4 period ns", sck_period, 16);
    wr(8'h14, 32'h100F);
    burst(2, 2, 2, 2, 8'h55);
    chk(sck_period == 128, "R9 divide by 32 period ns", sck_period, 128);
    wr(8'h14, 32'h0);
    burst(1, 0, 0, 0, 8'h66);
    chk(sck_period == 8, "R9 default mode period ns", sck_period, 8);

    // R11 RX overflow
    wr(8'h14, 32'h1000);
    burst(70, 4, 4, 4, 8'h77);

    // random bursts
    for (int r = 0; r < 6; r++) begin
      int b, t, s;
      b = 1 + int'($urandom % 40);
      t = int'($urandom % (b + 2));
      s = ($urandom % 2) ? t : int'($urandom % (b + 2));
      wr(8'h14, {19'd0, 1'b1, 8'd0, 4'($urandom % 4)});
      burst(b, t, s, (t > 64) ? 64 : t, 8'($urandom));
    end

    summary();
  end
endmodule